// File: doc/BRIEF.md
# Integer ALU and Shifter

This block is the integer execution stage of a simple in-order RISC pipeline. Each cycle it can take two 32-bit register values, a 16-bit instruction immediate, a 5-bit constant shift amount and an operation code. One clock edge later it presents a 32-bit result, a write enable for the destination register and an overflow exception flag.

It covers these operations:

- Add and subtract, in an overflow-trapping form and a non-trapping form.
- Bitwise AND, OR, XOR and NOR.
- Signed and unsigned set-less-than.
- Load of an immediate into the upper half of the result.
- Logical and arithmetic shifts, with the amount taken from a constant field or from a register.

How the immediate is extended depends on the operation. Logic operations zero-extend it. Arithmetic and compare operations sign-extend it, and this includes the unsigned compare.

Top module: `int_exec_unit`

## Requirements
- R1: When `rst_n` is low at a rising clock edge, `res_o`, `wr_en_o` and `ovf_o` are all zero after that edge.
- R2: The outputs are registered. An operation presented with `in_valid_i` high at a rising edge appears on the outputs after that edge. With `in_valid_i` low, `wr_en_o` and `ovf_o` are 0 after the edge. The `op_i` codes are: 0 ADD, 1 ADDU, 2 SUB, 3 SUBU, 4 ADDI, 5 ADDIU, 6 AND, 7 OR, 8 XOR, 9 NOR, 10 ANDI, 11 ORI, 12 XORI, 13 SLT, 14 SLTU, 15 SLTI, 16 SLTIU, 17 LUI, 18 SLL, 19 SRL, 20 SRA, 21 SLLV, 22 SRLV, 23 SRAV.
- R3: ADD, SUB and ADDI set `ovf_o` when the 32-bit two's-complement result overflows. In that case `wr_en_o` is 0 and `res_o` holds the wrapped value. ADDU, SUBU and ADDIU never set `ovf_o` and always write.
- R4: ADDI and ADDIU add `rs_i` to the immediate sign-extended to 32 bits. SUB and SUBU compute `rs_i - rt_i`.
- R5: AND, OR, XOR and NOR combine `rs_i` with `rt_i`. ANDI, ORI and XORI combine `rs_i` with the immediate zero-extended to 32 bits.
- R6: SLT and SLTI give 1 when `rs_i` is less than the second operand compared as signed, and 0 otherwise. SLTU and SLTIU compare as unsigned. SLTIU compares against the sign-extended immediate.
- R7: LUI gives the immediate in bits 31:16 and zero in bits 15:0. `rs_i` has no effect.
- R8: SLL, SRL and SRA shift `rt_i` by `shamt_i`. SRA fills with the sign bit and the other two fill with zero. A shift by 0 passes `rt_i` unchanged.
- R9: SLLV, SRLV and SRAV shift `rt_i` by `rs_i[4:0]`. The upper bits of `rs_i` are ignored.
- R10: Codes 24 to 31 give `res_o` 0, `wr_en_o` 0 and `ovf_o` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid_i | input | 1 | An operation is presented this cycle |
| op_i | input | 5 | Operation code |
| rs_i | input | 32 | First register operand |
| rt_i | input | 32 | Second register operand, and the shifted value |
| imm_i | input | 16 | Instruction immediate |
| shamt_i | input | 5 | Constant shift amount |
| res_o | output | 32 | Result |
| wr_en_o | output | 1 | Destination register write enable |
| ovf_o | output | 1 | Overflow exception |

## Verification
Every result, the write enable and the overflow flag are due exactly one rising edge after the operation is presented, because each passes through a single output register. The bench changes inputs on the falling edge. It then reads the outputs on the following falling edge, which is half a cycle after the capturing edge. Reset is checked the same way: a valid operation is held at the edge where reset is low, and the outputs are read after that edge. The following cycle then shows that a new operation clears an earlier overflow.

// File: rtl/int_exec_pkg.sv
// Shared operation codes and widths for the integer execution unit.
package int_exec_pkg;
    localparam int XLEN  = 32;
    localparam int IMM_W = 16;

    typedef enum logic [4:0] {
        OP_ADD   = 5'd0,  OP_ADDU  = 5'd1,  OP_SUB   = 5'd2,  OP_SUBU  = 5'd3,
        OP_ADDI  = 5'd4,  OP_ADDIU = 5'd5,  OP_AND   = 5'd6,  OP_OR    = 5'd7,
        OP_XOR   = 5'd8,  OP_NOR   = 5'd9,  OP_ANDI  = 5'd10, OP_ORI   = 5'd11,
        OP_XORI  = 5'd12, OP_SLT   = 5'd13, OP_SLTU  = 5'd14, OP_SLTI  = 5'd15,
        OP_SLTIU = 5'd16, OP_LUI   = 5'd17, OP_SLL   = 5'd18, OP_SRL   = 5'd19,
        OP_SRA   = 5'd20, OP_SLLV  = 5'd21, OP_SRLV  = 5'd22, OP_SRAV  = 5'd23
    } alu_op_e;
endpackage

// File: rtl/alu_operand_sel.sv
// Selects the second operand: the register value, or the immediate
// extended per operation (zero for logic, sign for arithmetic/compare).
// Assumes the op code is already decoded to the package enum.
module alu_operand_sel
    import int_exec_pkg::*;
#(
    parameter int W     = XLEN,
    parameter int IMM_B = IMM_W
) (
    input  alu_op_e         op,
    input  logic [W-1:0]    rt_val,
    input  logic [IMM_B-1:0] imm,
    output logic [W-1:0]    b_out
);
    localparam int PAD = W - IMM_B;

    // Pick the operand source and extension kind.
    always_comb begin
        unique case (op)
            OP_ADDI, OP_ADDIU, OP_SLTI, OP_SLTIU:
                b_out = {{PAD{imm[IMM_B-1]}}, imm};
            OP_ANDI, OP_ORI, OP_XORI:
                b_out = {{PAD{1'b0}}, imm};
            default:
                b_out = rt_val;
        endcase
    end
endmodule

// File: rtl/alu_addsub.sv
// Adder/subtractor with two's-complement overflow detect and both
// signed and unsigned less-than outputs. Purely combinational.
module alu_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         ovf,
    output logic         lt_s,
    output logic         lt_u
);
    logic [W-1:0] b_eff;

    // Add or subtract, then flag a sign change not explained by the operands.
    always_comb begin
        b_eff = sub ? ~b : b;
        sum   = a + b_eff + {{(W-1){1'b0}}, sub};
        ovf   = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
    end

    // Magnitude relations used by the set-less-than family.
    always_comb begin
        lt_s = $signed(a) < $signed(b);
        lt_u = a < b;
    end
endmodule

// File: rtl/alu_shifter.sv
// Logarithmic barrel shifter: right shifts with zero or sign fill, left
// shifts by bit-reversing around the right shifter. W must be a power of two.
module alu_shifter #(
    parameter int W = 32
) (
    input  logic [W-1:0]         din,
    input  logic [$clog2(W)-1:0] amt,
    input  logic                 left,
    input  logic                 arith,
    output logic [W-1:0]         dout
);
    localparam int STG = $clog2(W);

    logic [W-1:0] stage [STG+1];
    logic         fill;

    // Reverse the input for left shifts and pick the fill bit.
    always_comb begin
        for (int i = 0; i < W; i++) stage[0][i] = left ? din[W-1-i] : din[i];
        fill = arith & ~left & din[W-1];
    end

    genvar k;
    generate
        for (k = 0; k < STG; k++) begin : g_stage
            localparam int D = 1 << k;
            // Shift right by 2^k when this amount bit is set.
            always_comb begin
                stage[k+1] = amt[k] ? {{D{fill}}, stage[k][W-1:D]} : stage[k];
            end
        end
    endgenerate

    // Undo the reversal for left shifts.
    always_comb begin
        for (int i = 0; i < W; i++) dout[i] = left ? stage[STG][W-1-i] : stage[STG][i];
    end
endmodule

// File: rtl/int_exec_unit.sv
// Single-cycle integer execution unit with registered outputs.
// Computes one operation per valid cycle; the result, write enable and
// overflow flag appear after the next rising edge. Synchronous active-low reset.
module int_exec_unit
    import int_exec_pkg::*;
#(
    parameter int W     = XLEN,
    parameter int IMM_B = IMM_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid_i,
    input  logic [4:0]         op_i,
    input  logic [W-1:0]       rs_i,
    input  logic [W-1:0]       rt_i,
    input  logic [IMM_B-1:0]   imm_i,
    input  logic [$clog2(W)-1:0] shamt_i,
    output logic [W-1:0]       res_o,
    output logic               wr_en_o,
    output logic               ovf_o
);
    localparam int SH_W = $clog2(W);

    alu_op_e      op;
    logic [W-1:0] b_val, sum, sh_out, res_d;
    logic         ovf_raw, lt_s, lt_u, is_sub, sh_left, sh_arith, legal, trap, ovf_d;
    logic [SH_W-1:0] sh_amt;

    assign op = alu_op_e'(op_i);

    alu_operand_sel #(.W(W), .IMM_B(IMM_B)) u_opsel (
        .op(op), .rt_val(rt_i), .imm(imm_i), .b_out(b_val)
    );

    alu_addsub #(.W(W)) u_addsub (
        .a(rs_i), .b(b_val), .sub(is_sub),
        .sum(sum), .ovf(ovf_raw), .lt_s(lt_s), .lt_u(lt_u)
    );

    alu_shifter #(.W(W)) u_shift (
        .din(rt_i), .amt(sh_amt), .left(sh_left), .arith(sh_arith), .dout(sh_out)
    );

    // Decode shifter controls and the amount source.
    always_comb begin
        is_sub   = (op == OP_SUB) || (op == OP_SUBU);
        sh_left  = (op == OP_SLL) || (op == OP_SLLV);
        sh_arith = (op == OP_SRA) || (op == OP_SRAV);
        sh_amt   = (op == OP_SLLV || op == OP_SRLV || op == OP_SRAV) ? rs_i[SH_W-1:0] : shamt_i;
        trap     = (op == OP_ADD) || (op == OP_SUB) || (op == OP_ADDI);
    end

    // Select the result for the decoded operation.
    always_comb begin
        legal = 1'b1;
        unique case (op)
            OP_ADD, OP_ADDU, OP_SUB, OP_SUBU, OP_ADDI, OP_ADDIU: res_d = sum;
            OP_AND, OP_ANDI:            res_d = rs_i & b_val;
            OP_OR,  OP_ORI:             res_d = rs_i | b_val;
            OP_XOR, OP_XORI:            res_d = rs_i ^ b_val;
            OP_NOR:                     res_d = ~(rs_i | b_val);
            OP_SLT, OP_SLTI:            res_d = {{(W-1){1'b0}}, lt_s};
            OP_SLTU, OP_SLTIU:          res_d = {{(W-1){1'b0}}, lt_u};
            OP_LUI:                     res_d = {imm_i, {(W-IMM_B){1'b0}}};
            OP_SLL, OP_SRL, OP_SRA,
            OP_SLLV, OP_SRLV, OP_SRAV:  res_d = sh_out;
            default: begin
                res_d = '0;
                legal = 1'b0;
            end
        endcase
        ovf_d = in_valid_i && trap && ovf_raw;
    end

    // Output register: cleared by reset, loaded every cycle otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_o   <= '0;
            wr_en_o <= 1'b0;
            ovf_o   <= 1'b0;
        end else begin
            res_o   <= res_d;
            wr_en_o <= in_valid_i && legal && !ovf_d;
            ovf_o   <= ovf_d;
        end
    end

    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (res_o == '0) && !wr_en_o && !ovf_o);

    assert_idle_no_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid_i |=> !wr_en_o && !ovf_o);

    assert_no_write_on_ovf_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |-> !wr_en_o);

    assert_unsigned_no_trap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_ADDU || op_i == OP_SUBU || op_i == OP_ADDIU) |=> !ovf_o);

    assert_slt_boolean_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && (op_i == OP_SLT || op_i == OP_SLTU || op_i == OP_SLTI || op_i == OP_SLTIU))
        |=> (res_o[W-1:1] == '0) && wr_en_o);

    assert_lui_placement_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && op_i == OP_LUI) |=> res_o == {$past(imm_i), {(W-IMM_B){1'b0}}});

    assert_undefined_op_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i > OP_SRAV) |=> (res_o == '0) && !wr_en_o && !ovf_o);
endmodule

// File: tb/int_exec_unit_tb_top.sv
module int_exec_unit_tb_top;
    import int_exec_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid_i = 1'b0;
    logic [4:0]  op_i = '0;
    logic [31:0] rs_i = '0, rt_i = '0;
    logic [15:0] imm_i = '0;
    logic [4:0]  shamt_i = '0;
    logic [31:0] res_o;
    logic        wr_en_o, ovf_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    int_exec_unit dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid_i), .op_i(op_i),
        .rs_i(rs_i), .rt_i(rt_i), .imm_i(imm_i), .shamt_i(shamt_i),
        .res_o(res_o), .wr_en_o(wr_en_o), .ovf_o(ovf_o)
    );

    typedef struct packed {
        logic [4:0]  op;
        logic [31:0] a;
        logic [31:0] b;
        logic [15:0] imm;
        logic [4:0]  sh;
        logic [31:0] res;
        logic        we;
        logic        ov;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 28;
    localparam vec_t VECS [NV] = '{
        '{OP_ADD,   32'd5,        32'd7,        16'h0,    5'd0,  32'd12,       1'b1, 1'b0, 8'd3},  // R3
        '{OP_ADD,   32'h7FFFFFFF, 32'd1,        16'h0,    5'd0,  32'h80000000, 1'b0, 1'b1, 8'd3},  // R3
        '{OP_ADDU,  32'h7FFFFFFF, 32'd1,        16'h0,    5'd0,  32'h80000000, 1'b1, 1'b0, 8'd3},  // R3
        '{OP_SUB,   32'h80000000, 32'd1,        16'h0,    5'd0,  32'h7FFFFFFF, 1'b0, 1'b1, 8'd3},  // R3
        '{OP_SUBU,  32'd0,        32'd1,        16'h0,    5'd0,  32'hFFFFFFFF, 1'b1, 1'b0, 8'd4},  // R4
        '{OP_ADDI,  32'd10,       32'h0,        16'hFFFF, 5'd0,  32'd9,        1'b1, 1'b0, 8'd4},  // R4
        '{OP_ADDI,  32'h7FFFFFFF, 32'h0,        16'h0001, 5'd0,  32'h80000000, 1'b0, 1'b1, 8'd3},  // R3
        '{OP_ADDIU, 32'd0,        32'h0,        16'h8000, 5'd0,  32'hFFFF8000, 1'b1, 1'b0, 8'd4},  // R4
        '{OP_AND,   32'hF0F0F0F0, 32'hFF00FF00, 16'h0,    5'd0,  32'hF000F000, 1'b1, 1'b0, 8'd5},  // R5
        '{OP_OR,    32'hF0F0F0F0, 32'hFF00FF00, 16'h0,    5'd0,  32'hFFF0FFF0, 1'b1, 1'b0, 8'd5},  // R5
        '{OP_XOR,   32'hF0F0F0F0, 32'hFF00FF00, 16'h0,    5'd0,  32'h0FF00FF0, 1'b1, 1'b0, 8'd5},  // R5
        '{OP_NOR,   32'hF0F0F0F0, 32'hFF00FF00, 16'h0,    5'd0,  32'h000F000F, 1'b1, 1'b0, 8'd5},  // R5
        '{OP_ANDI,  32'hFFFFFFFF, 32'h0,        16'h8001, 5'd0,  32'h00008001, 1'b1, 1'b0, 8'd5},  // R5
        '{OP_ORI,   32'h12340000, 32'h0,        16'hABCD, 5'd0,  32'h1234ABCD, 1'b1, 1'b0, 8'd5},  // R5
        '{OP_XORI,  32'hFFFF0000, 32'h0,        16'hFFFF, 5'd0,  32'hFFFFFFFF, 1'b1, 1'b0, 8'd5},  // R5
        '{OP_SLT,   32'hFFFFFFFF, 32'd1,        16'h0,    5'd0,  32'd1,        1'b1, 1'b0, 8'd6},  // R6
        '{OP_SLTU,  32'hFFFFFFFF, 32'd1,        16'h0,    5'd0,  32'd0,        1'b1, 1'b0, 8'd6},  // R6
        '{OP_SLTI,  32'd5,        32'h0,        16'hFFFF, 5'd0,  32'd0,        1'b1, 1'b0, 8'd6},  // R6
        '{OP_SLTIU, 32'd5,        32'h0,        16'hFFFF, 5'd0,  32'd1,        1'b1, 1'b0, 8'd6},  // R6
        '{OP_LUI,   32'hFFFFFFFF, 32'h0,        16'hBEEF, 5'd0,  32'hBEEF0000, 1'b1, 1'b0, 8'd7},  // R7
        '{OP_SLL,   32'h0,        32'h00000001, 16'h0,    5'd31, 32'h80000000, 1'b1, 1'b0, 8'd8},  // R8
        '{OP_SRL,   32'h0,        32'h80000000, 16'h0,    5'd4,  32'h08000000, 1'b1, 1'b0, 8'd8},  // R8
        '{OP_SRA,   32'h0,        32'h80000000, 16'h0,    5'd4,  32'hF8000000, 1'b1, 1'b0, 8'd8},  // R8
        '{OP_SLL,   32'h0,        32'hDEADBEEF, 16'h0,    5'd0,  32'hDEADBEEF, 1'b1, 1'b0, 8'd8},  // R8
        '{OP_SLLV,  32'h00000024, 32'h0000000F, 16'h0,    5'd9,  32'h000000F0, 1'b1, 1'b0, 8'd9},  // R9
        '{OP_SRLV,  32'hFFFFFFE1, 32'h80000000, 16'h0,    5'd0,  32'h40000000, 1'b1, 1'b0, 8'd9},  // R9
        '{OP_SRAV,  32'h0000003F, 32'h80000000, 16'h0,    5'd0,  32'hFFFFFFFF, 1'b1, 1'b0, 8'd9},  // R9
        '{5'd24,    32'hFFFFFFFF, 32'hFFFFFFFF, 16'hFFFF, 5'd3,  32'd0,        1'b0, 1'b0, 8'd10}  // R10
    };

    task automatic check(input int req, input logic [31:0] er, input logic ew, input logic eo);
        n_chk++;
        if (res_o !== er || wr_en_o !== ew || ovf_o !== eo) begin
            n_fail++;
            $display("FAIL R%0d: got res=%h we=%b ovf=%b, expected res=%h we=%b ovf=%b",
                     req, res_o, wr_en_o, ovf_o, er, ew, eo);
        end
    endtask

    task automatic drive(input logic v, input logic [4:0] op, input logic [31:0] a,
                         input logic [31:0] b, input logic [15:0] imm, input logic [4:0] sh);
        in_valid_i = v; op_i = op; rs_i = a; rt_i = b; imm_i = imm; shamt_i = sh;
    endtask

    initial begin
        // R1: reset held across two edges with a valid op presented
        drive(1'b1, OP_ADDU, 32'd1, 32'd2, 16'h0, 5'd0);
        @(negedge clk); @(negedge clk);
        check(1, 32'd0, 1'b0, 1'b0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(1'b1, VECS[i].op, VECS[i].a, VECS[i].b, VECS[i].imm, VECS[i].sh);
            @(negedge clk);
            check(int'(VECS[i].req), VECS[i].res, VECS[i].we, VECS[i].ov);
        end

        // R3: overflow raised, then cleared by the next non-trapping op
        drive(1'b1, OP_SUB, 32'h7FFFFFFF, 32'hFFFFFFFF, 16'h0, 5'd0);
        @(negedge clk);
        check(3, 32'h80000000, 1'b0, 1'b1);
        drive(1'b1, OP_SUBU, 32'h7FFFFFFF, 32'hFFFFFFFF, 16'h0, 5'd0);
        @(negedge clk);
        check(3, 32'h80000000, 1'b1, 1'b0);

        // R2: idle cycle with an overflowing add on the inputs writes nothing
        drive(1'b0, OP_ADD, 32'h7FFFFFFF, 32'd1, 16'h0, 5'd0);
        @(negedge clk);
        check(2, 32'h80000000, 1'b0, 1'b0);

        // R1: reset in mid-run while an op is valid
        drive(1'b1, OP_ORI, 32'h0, 32'h0, 16'h1234, 5'd0);
        rst_n = 1'b0;
        @(negedge clk);
        check(1, 32'd0, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check(5, 32'h00001234, 1'b1, 1'b0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got no completion, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule